// File: doc/BRIEF.md
# Compliance Pattern Generator with Disparity Control

This block produces the repeating link compliance test sequence as parallel transmit symbols for a downstream 8b/10b encoder. On every clock while it is enabled, it presents the next symbols of the four-symbol cycle. Each output byte carries a flag that marks it as a control (K) character. Each byte also carries a second flag. That flag asks the encoder to start that symbol with negative running disparity. The flag is raised only on the first K28.5 after the generator starts.

The output path is one byte lane wide in narrow mode and two byte lanes wide in wide mode. A level input picks the mode. It is meant to be held steady while the generator runs and changed only while `enable` is low. Dropping `enable` clears the outputs on the next clock and rewinds the sequence. Raising it again restarts the cycle from the beginning, with the disparity request once more.

Top module: `compliance_pattern_gen`

## Requirements
- R1: While `rst_n` is low, `tx_byte`, `tx_kflag` and `tx_force_neg` are all zero.
- R2: After a rising clock edge at which `enable` is low, all three outputs are zero.
- R3: In narrow mode (`wide_mode`=0), a rising edge with `enable` high sets `tx_byte[7:0]` to the next byte of the cycle 0xBC, 0xB5, 0xBC, 0x4A. The cycle starts with 0xBC at the first such edge after reset, or after an edge with `enable` low.
- R4: In narrow mode, `tx_kflag[0]` is 1 exactly when `tx_byte[7:0]` carries 0xBC (K28.5), and 0 for 0xB5 and 0x4A.
- R5: In narrow mode, `tx_force_neg[0]` is 1 only on the first 0xBC output after reset. It is 0 on every later repetition.
- R6: In wide mode (`wide_mode`=1), each enabled edge outputs the next word of the two-word cycle. The first word has high byte 0xB5 and low byte 0xBC. The second word has high byte 0x4A and low byte 0xBC. The cycle starts with the first word.
- R7: In wide mode, while the pattern runs, `tx_kflag` is 2'b01 on every word, so only the low byte is a control character.
- R8: In wide mode, `tx_force_neg` is 2'b01 on the first word after reset and 2'b00 on every later word.
- R9: In narrow mode, `tx_byte[15:8]`, `tx_kflag[1]` and `tx_force_neg[1]` stay zero.
- R10: After `enable` has been low for at least one edge and rises again, the cycle restarts from its first symbol, and the force flag is raised once more on that first symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the pattern while high; clear and rewind while low |
| wide_mode | input | 1 | 0 selects one byte per clock, 1 selects two bytes per clock |
| tx_byte | output | 16 | Transmit bytes, lane 0 in bits 7:0, lane 1 in bits 15:8 |
| tx_kflag | output | 2 | Per-lane control-character flag |
| tx_force_neg | output | 2 | Per-lane request for negative starting disparity |

## Verification
The bench builds the block with its default configuration: a byte lane of 8 bits, two lanes at most and a four-symbol cycle. Both lane widths are therefore exercised through the `wide_mode` input in one run. It runs narrow mode across several full cycles and stops part-way through one. It then re-enables and switches to wide mode while idle. Each case lets the bench confirm that the sequence rewinds and that the disparity request appears once at the start of every run.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    localparam int SYM_W   = 8;
    localparam int LANES   = 2;
    localparam int PAT_LEN = 4;
    localparam int PTR_W   = $clog2(PAT_LEN);
    localparam int DATA_W  = SYM_W * LANES;

    localparam logic [SYM_W-1:0] SYM_K28_5 = 8'hBC;
    localparam logic [SYM_W-1:0] SYM_D21_5 = 8'hB5;
    localparam logic [SYM_W-1:0] SYM_D10_2 = 8'h4A;

    // Symbol at a given position of the compliance cycle.
    function automatic logic [SYM_W-1:0] pat_sym(input logic [PTR_W-1:0] idx);
        case (idx)
            2'd0:    pat_sym = SYM_K28_5;
            2'd1:    pat_sym = SYM_D21_5;
            2'd2:    pat_sym = SYM_K28_5;
            default: pat_sym = SYM_D10_2;
        endcase
    endfunction

    // Even positions hold the comma control character.
    function automatic logic pat_is_k(input logic [PTR_W-1:0] idx);
        pat_is_k = (idx[0] == 1'b0);
    endfunction

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             first;
    } seq_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  kflag;
        logic [LANES-1:0]  fneg;
    } tx_out_t;

endpackage

// File: rtl/cpg_seq.sv
module cpg_seq
    import cpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wide_mode,
    output logic [PTR_W-1:0] ptr_o,
    output logic             first_o
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.ptr   = '0;
            st_d.first = 1'b1;
        end else begin
            st_d.ptr   = st_q.ptr + (wide_mode ? PTR_W'(LANES) : PTR_W'(1));
            st_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr   <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o   = st_q.ptr;
    assign first_o = st_q.first;

    // The first-symbol marker is only ever pending at the start of the cycle.
    assert_first_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.first |-> (st_q.ptr == '0));

    // An idle edge rewinds the sequence and re-arms the force request.
    assert_rewind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.ptr == '0) && st_q.first);

endmodule

// File: rtl/cpg_lane.sv
module cpg_lane
    import cpg_pkg::*;
#(
    parameter int LANE_IDX = 0
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic             first,
    input  logic             wide_mode,
    output logic [SYM_W-1:0] sym,
    output logic             kflag,
    output logic             fneg
);

    localparam logic [PTR_W-1:0] LANE_OFF = PTR_W'(LANE_IDX);
    localparam logic [PTR_W-1:0] WORD_MSK = ~PTR_W'(LANES - 1);

    logic             active;
    logic [PTR_W-1:0] idx;

    always_comb begin
        active = wide_mode || (LANE_IDX == 0);
        idx    = wide_mode ? ((ptr & WORD_MSK) | LANE_OFF) : ptr;
        sym    = active ? pat_sym(idx) : '0;
        kflag  = active && pat_is_k(idx);
        fneg   = active && first && (idx == '0);
    end

endmodule

// File: rtl/compliance_pattern_gen.sv
module compliance_pattern_gen
    import cpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wide_mode,
    output logic [DATA_W-1:0] tx_byte,
    output logic [LANES-1:0]  tx_kflag,
    output logic [LANES-1:0]  tx_force_neg
);

    logic [PTR_W-1:0] seq_ptr;
    logic             seq_first;

    cpg_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .wide_mode (wide_mode),
        .ptr_o     (seq_ptr),
        .first_o   (seq_first)
    );

    logic [SYM_W-1:0] lane_sym [LANES];
    logic [LANES-1:0] lane_k;
    logic [LANES-1:0] lane_neg;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cpg_lane #(.LANE_IDX(g)) u_lane (
            .ptr       (seq_ptr),
            .first     (seq_first),
            .wide_mode (wide_mode),
            .sym       (lane_sym[g]),
            .kflag     (lane_k[g]),
            .fneg      (lane_neg[g])
        );
    end

    tx_out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (enable) begin
            for (int i = 0; i < LANES; i++) begin
                out_d.data[i*SYM_W +: SYM_W] = lane_sym[i];
            end
            out_d.kflag = lane_k;
            out_d.fneg  = lane_neg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tx_byte      = out_q.data;
    assign tx_kflag     = out_q.kflag;
    assign tx_force_neg = out_q.fneg;

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (tx_byte == '0) && (tx_kflag == '0) && (tx_force_neg == '0));

    assert_force_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_force_neg != '0) |=> (tx_force_neg == '0));

    assert_force_on_comma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_force_neg != '0) |-> (tx_force_neg == 2'b01) && tx_kflag[0]
                                 && (tx_byte[SYM_W-1:0] == SYM_K28_5));

    assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !wide_mode) |=> (tx_byte[DATA_W-1:SYM_W] == '0)
                                   && !tx_kflag[1] && !tx_force_neg[1]);

    assert_wide_kmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wide_mode) |=> (tx_kflag == 2'b01));

endmodule

// File: tb/compliance_pattern_gen_tb.sv
module compliance_pattern_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wide_mode = 1'b0;
    logic [15:0] tx_byte;
    logic [1:0]  tx_kflag;
    logic [1:0]  tx_force_neg;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit reen = 1'b0;

    always #5 clk = ~clk;

    compliance_pattern_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .wide_mode    (wide_mode),
        .tx_byte      (tx_byte),
        .tx_kflag     (tx_kflag),
        .tx_force_neg (tx_force_neg)
    );

    function automatic logic [7:0] cyc_byte(input int p);
        case (p % 4)
            0:       cyc_byte = 8'hBC;
            1:       cyc_byte = 8'hB5;
            2:       cyc_byte = 8'hBC;
            default: cyc_byte = 8'h4A;
        endcase
    endfunction

    // Behavioural reference: ctx 0 reset, 1 idle, 2 narrow, 3 wide.
    int          ctx = 0;
    int          pos = 0;
    bit          pend = 1'b1;
    logic [15:0] e_byte = '0;
    logic [1:0]  e_k = '0;
    logic [1:0]  e_neg = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx <= 0; pos <= 0; pend <= 1'b1;
            e_byte <= '0; e_k <= '0; e_neg <= '0;
        end else if (!enable) begin
            ctx <= 1; pos <= 0; pend <= 1'b1;
            e_byte <= '0; e_k <= '0; e_neg <= '0;
        end else if (!wide_mode) begin
            ctx <= 2;
            e_byte <= {8'h00, cyc_byte(pos)};
            e_k    <= {1'b0, cyc_byte(pos) == 8'hBC};
            e_neg  <= {1'b0, pend};
            pos <= pos + 1; pend <= 1'b0;
        end else begin
            ctx <= 3;
            e_byte <= {cyc_byte(pos + 1), cyc_byte(pos)};
            e_k    <= 2'b01;
            e_neg  <= pend ? 2'b01 : 2'b00;
            pos <= pos + 2; pend <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            case (ctx)
                0: begin
                    check("R1 byte", tx_byte, e_byte);
                    check("R1 kflag", {14'd0, tx_kflag}, {14'd0, e_k});
                    check("R1 force", {14'd0, tx_force_neg}, {14'd0, e_neg});
                end
                1: begin
                    check("R2 byte", tx_byte, e_byte);
                    check("R2 kflag", {14'd0, tx_kflag}, {14'd0, e_k});
                    check("R2 force", {14'd0, tx_force_neg}, {14'd0, e_neg});
                end
                2: begin
                    check("R3 byte", {8'd0, tx_byte[7:0]}, {8'd0, e_byte[7:0]});
                    check("R4 kflag", {15'd0, tx_kflag[0]}, {15'd0, e_k[0]});
                    check((reen && e_neg[0]) ? "R10 force" : "R5 force",
                          {15'd0, tx_force_neg[0]}, {15'd0, e_neg[0]});
                    check("R9 upper", {6'd0, tx_byte[15:8], tx_kflag[1], tx_force_neg[1]},
                          {6'd0, e_byte[15:8], e_k[1], e_neg[1]});
                end
                default: begin
                    check("R6 word", tx_byte, e_byte);
                    check("R7 kflag", {14'd0, tx_kflag}, {14'd0, e_k});
                    check((reen && e_neg != 0) ? "R10 force" : "R8 force",
                          {14'd0, tx_force_neg}, {14'd0, e_neg});
                end
            endcase
        end
    end

    task automatic step(input int n, input bit en, input bit wd);
        @(negedge clk); #1;
        enable = en; wide_mode = wd;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        step(10, 1'b1, 1'b0);   // narrow, stop mid-cycle
        step(3, 1'b0, 1'b0);
        reen = 1'b1;
        step(9, 1'b1, 1'b0);    // narrow re-enable
        step(2, 1'b0, 1'b0);
        reen = 1'b0;
        step(2, 1'b0, 1'b1);    // switch to wide while idle
        step(7, 1'b1, 1'b1);
        step(2, 1'b0, 1'b1);
        reen = 1'b1;
        step(5, 1'b1, 1'b1);    // wide re-enable
        step(2, 1'b0, 1'b1);
        @(negedge clk);
        #1 rst_n = 1'b0;
        reen = 1'b0;
        step(2, 1'b1, 1'b1);    // reset while enabled
        #1 rst_n = 1'b1;
        step(4, 1'b1, 1'b1);
        @(negedge clk); #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule